// File: doc/BRIEF.md
# Serial Idle-Locked Stream Descrambler

This block recovers plain data from a scrambled 100BASE-X receive bit stream, one bit per clock whenever the input strobe is high. It keeps an 11-bit key generator whose recurrence matches the transmit scrambler, and XORs each scrambled bit with the next key bit. While it is not locked, the block assumes the line carries scrambled idle, which is all ones before scrambling. Under that assumption the inverted scrambled bit is the key bit, so it loads the generator with inverted input bits. It declares lock once its own descrambled output shows a long enough unbroken run of ones.

Once locked, the generator runs freely. The recovered bits appear on the output with a valid strobe. They are not aligned to code-group boundaries; a later stage finds those. A hold timer guards the lock. Each time the descrambled stream shows a shorter run of ones, the timer is restarted. If a full window passes without such a run, the block drops lock, clears its key generator and its run counter, and starts acquisition again.

Top module: `serial_idle_descrambler`

## Requirements
- R1: After reset, and at all times while `locked` is low, `outValid` is low.
- R2: Key bits follow k[n] = k[n-11] XOR k[n-9]. While locked, each accepted input bit gives plain = scrambled XOR key. That plain bit appears on `outBit`, with `outValid` high, after the clock edge that accepted it.
- R3: From reset, `locked` rises on the edge that accepts the 71st consecutive valid idle bit. The first 11 bits only fill the key generator; the next 60 ones make up 12 idle code-groups of five ones each.
- R4: When no re-arm happens, `locked` falls exactly HOLD_CYCLES clock cycles after the lock-entry edge or after the last re-arm edge. Cycles with `inValid` low also count toward the window.
- R5: While locked, a run of REARM_RUN (58) consecutive descrambled ones restarts the window on the edge of its last bit. A run of 57 ones followed by a zero does not restart it.
- R6: When lock is lost, the key generator and the ones counter are cleared and acquisition starts over. The block can then lock again on the same continuing scrambled idle stream.
- R7: A cycle with `inValid` low advances nothing except the hold timer. In that cycle `outValid` is low and `outBit` is unchanged.
- R8: During acquisition, a single non-idle bit delays lock. `locked` then rises on the 71st consecutive valid idle bit after that non-idle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | High when `inBit` carries a received bit |
| inBit | input | 1 | Scrambled received bit |
| outBit | output | 1 | Descrambled bit, not aligned to code-group boundaries |
| outValid | output | 1 | High for one cycle per descrambled bit while locked |
| locked | output | 1 | High while the descrambler is synchronized |

## Verification
Every result is registered. A bit driven before edge N shows up on `outBit`/`outValid` just after edge N. `locked` changes on that same edge when the bit completes the lock run. When the hold window expires, `locked` falls exactly HOLD_CYCLES edges after the lock-entry or re-arm edge. The bench applies each input at the falling edge and reads the outputs 1 ns after the next rising edge. It counts one step per clock, so each lock, re-arm and timeout check falls on the exact edge the requirement names, including the one just before it. The bench models the transmit scrambler itself and feeds it plain data that it chooses, so the expected output is always the plain data it fed in.

// File: rtl/serial_idle_descrambler_pkg.sv
package serial_idle_descrambler_pkg;

  typedef enum logic {
    ST_ACQUIRE = 1'b0,
    ST_LOCKED  = 1'b1
  } lock_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // accept the current input bit
    logic acquire;   // load key from inverted input instead of free-running
    logic clearKey;  // wipe the key generator
    logic emitEn;    // publish the plain bit on the output
  } dsc_strobe_t;

endpackage

// File: rtl/descr_datapath.sv
module descr_datapath
  import serial_idle_descrambler_pkg::*;
#(
  parameter int KEY_W = 11,
  parameter int TAP_B = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inBit,
  input  dsc_strobe_t strobe,
  output logic        plainBit,
  output logic        outBit,
  output logic        outValid
);

  localparam int HI_IDX  = KEY_W - 1;
  localparam int TAP_IDX = TAP_B - 1;

  logic [KEY_W-1:0] keyQ;
  logic             predKey;
  logic             keyIn;

  always_comb begin
    predKey  = keyQ[HI_IDX] ^ keyQ[TAP_IDX];
    plainBit = inBit ^ predKey;
    keyIn    = strobe.acquire ? ~inBit : predKey;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyQ <= '0;
    end else if (strobe.clearKey) begin
      keyQ <= '0;
    end else if (strobe.shiftEn) begin
      keyQ <= {keyQ[KEY_W-2:0], keyIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBit   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.emitEn;
      if (strobe.emitEn) begin
        outBit <= plainBit;
      end
    end
  end

endmodule

// File: rtl/descr_control.sv
module descr_control
  import serial_idle_descrambler_pkg::*;
#(
  parameter int KEY_W       = 11,
  parameter int LOCK_RUN    = 60,
  parameter int REARM_RUN   = 58,
  parameter int HOLD_CYCLES = 90250
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        plainBit,
  output dsc_strobe_t strobe,
  output logic        locked
);

  localparam int MAX_RUN = (LOCK_RUN > REARM_RUN) ? LOCK_RUN : REARM_RUN;
  localparam int RUN_W   = $clog2(MAX_RUN + 1);
  localparam int FILL_W  = $clog2(KEY_W + 1);
  localparam int TMR_W   = $clog2(HOLD_CYCLES);

  lock_state_t       stateQ;
  logic [FILL_W-1:0] fillQ;
  logic [RUN_W-1:0]  runQ;
  logic [TMR_W-1:0]  timerQ;

  logic fillDone;
  logic lockNow;
  logic rearm;
  logic expire;

  always_comb begin
    fillDone = (fillQ == FILL_W'(KEY_W));
    lockNow  = (stateQ == ST_ACQUIRE) && inValid && fillDone && plainBit &&
               (runQ == RUN_W'(LOCK_RUN - 1));
    rearm    = (stateQ == ST_LOCKED) && inValid && plainBit &&
               (runQ == RUN_W'(REARM_RUN - 1));
    expire   = (stateQ == ST_LOCKED) && !rearm &&
               (timerQ == TMR_W'(HOLD_CYCLES - 1));

    strobe.shiftEn  = inValid;
    strobe.acquire  = (stateQ == ST_ACQUIRE);
    strobe.clearKey = expire;
    strobe.emitEn   = inValid && (stateQ == ST_LOCKED) && !expire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_ACQUIRE;
      fillQ  <= '0;
      runQ   <= '0;
      timerQ <= '0;
    end else begin
      case (stateQ)
        ST_ACQUIRE: begin
          if (lockNow) begin
            stateQ <= ST_LOCKED;
            runQ   <= '0;
            timerQ <= '0;
          end else if (inValid) begin
            if (!fillDone) begin
              fillQ <= fillQ + 1'b1;
            end else if (plainBit) begin
              runQ <= runQ + 1'b1;
            end else begin
              runQ <= '0;
            end
          end
        end
        default: begin
          if (expire) begin
            stateQ <= ST_ACQUIRE;
            fillQ  <= '0;
            runQ   <= '0;
            timerQ <= '0;
          end else begin
            timerQ <= rearm ? '0 : timerQ + 1'b1;
            if (inValid) begin
              runQ <= (rearm || !plainBit) ? '0 : runQ + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign locked = (stateQ == ST_LOCKED);

endmodule

// File: rtl/serial_idle_descrambler.sv
module serial_idle_descrambler
  import serial_idle_descrambler_pkg::*;
#(
  parameter int KEY_W       = 11,
  parameter int TAP_B       = 9,
  parameter int LOCK_RUN    = 60,
  parameter int REARM_RUN   = 58,
  parameter int HOLD_CYCLES = 90250
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic inBit,
  output logic outBit,
  output logic outValid,
  output logic locked
);

  dsc_strobe_t strobe;
  logic        plainBit;

  descr_control #(
    .KEY_W      (KEY_W),
    .LOCK_RUN   (LOCK_RUN),
    .REARM_RUN  (REARM_RUN),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .plainBit(plainBit),
    .strobe  (strobe),
    .locked  (locked)
  );

  descr_datapath #(
    .KEY_W(KEY_W),
    .TAP_B(TAP_B)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .inBit   (inBit),
    .strobe  (strobe),
    .plainBit(plainBit),
    .outBit  (outBit),
    .outValid(outValid)
  );

endmodule

// File: rtl/serial_idle_descrambler_chk.sv
module serial_idle_descrambler_chk (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic outBit,
  input logic outValid,
  input logic locked
);

  AST_OUT_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> locked); // R1

  AST_GAP_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> !outValid); // R7

  AST_GAP_HOLDS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> $stable(outBit)); // R7

  AST_LOCK_ON_VALID: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(inValid)); // R3

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> !outValid); // R4

endmodule

bind serial_idle_descrambler serial_idle_descrambler_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .outBit  (outBit),
  .outValid(outValid),
  .locked  (locked)
);

// File: tb/sim_serial_idle_descrambler.sv
`timescale 1ns/1ps
module sim_serial_idle_descrambler;

  localparam int HOLD = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inBit = 1'b0;
  logic outBit, outValid, locked;

  int nChecks = 0;
  int nFails = 0;
  logic [10:0] txKey = 11'h5A3;

  // plain words fed while locked; expected output equals the word
  localparam logic [15:0] PLAIN_TAB [8] = '{
    16'hA5C3, 16'h0F0F, 16'hFFFE, 16'h1234,
    16'h8001, 16'h7FF7, 16'h5555, 16'hC0DE
  };

  always #5 clk = ~clk;

  serial_idle_descrambler #(.HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBit(inBit),
    .outBit(outBit), .outValid(outValid), .locked(locked)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at falling edge, sample 1 ns after rising edge
  task automatic step(input logic p, input logic v);
    logic k;
    @(negedge clk);
    if (v) begin
      k = txKey[10] ^ txKey[8];
      inBit = p ^ k;
      txKey = {txKey[9:0], k};
    end
    inValid = v;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic seenValid;
    logic [15:0] got;
    repeat (3) @(posedge clk);
    #1;
    check(locked == 1'b0, "R1 reset locked", locked, 0);
    check(outValid == 1'b0, "R1 reset outValid", outValid, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R3: 70 idle bits do not lock, the 71st does
    seenValid = 1'b0;
    for (int i = 0; i < 70; i++) begin
      step(1'b1, 1'b1);
      if (outValid) seenValid = 1'b1;
    end
    check(locked == 1'b0, "R3 no lock after 70 idle", locked, 0);
    check(seenValid == 1'b0, "R1 no output while unlocked", seenValid, 0);
    step(1'b1, 1'b1);
    check(locked == 1'b1, "R3 lock on 71st idle", locked, 1);

    // R5: 58 ones re-arm the window (reference edge = last of them)
    for (int i = 0; i < 58; i++) step(1'b1, 1'b1);

    // R2: table of plain words, output must match bit for bit
    for (int w = 0; w < 8; w++) begin
      got = '0;
      seenValid = 1'b1;
      for (int b = 15; b >= 0; b--) begin
        step(PLAIN_TAB[w][b], 1'b1);
        got[b] = outBit;
        if (!outValid) seenValid = 1'b0;
      end
      check(got == PLAIN_TAB[w] && seenValid, "R2 plain word", got, PLAIN_TAB[w]);
    end

    // R7: gaps produce nothing and keep the output bit
    begin
      logic keep;
      keep = outBit;
      seenValid = 1'b0;
      for (int i = 0; i < 5; i++) begin
        step(1'b0, 1'b0);
        if (outValid || outBit != keep) seenValid = 1'b1;
      end
      check(seenValid == 1'b0, "R7 gap silent and bit held", seenValid, 0);
      check(locked == 1'b1, "R7 gap keeps lock", locked, 1);
    end

    // R4: no re-arm; steps so far since re-arm = 128 + 5
    for (int i = 133; i < HOLD - 1; i++) step(i[0], 1'b1);
    check(locked == 1'b1, "R4 still locked one cycle before window end", locked, 1);
    step(1'b1, 1'b1);
    check(locked == 1'b0, "R4 lock drops at window end", locked, 0);
    check(outValid == 1'b0, "R1 no output on drop", outValid, 0);

    // R6/R8: reacquire; a stray zero restarts the 71-bit requirement
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    for (int i = 0; i < 70; i++) step(1'b1, 1'b1);
    check(locked == 1'b0, "R8 no lock 70 idle after a zero", locked, 0);
    step(1'b1, 1'b1);
    check(locked == 1'b1, "R6 relock on 71st idle after the zero", locked, 1);

    // R5 boundary: 57 ones then a zero do not re-arm
    for (int i = 0; i < 57; i++) step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    for (int i = 58; i < HOLD - 1; i++) step(i[0], 1'b1);
    check(locked == 1'b1, "R5 locked one cycle before window end", locked, 1);
    step(1'b1, 1'b1);
    check(locked == 1'b0, "R5 57-run did not re-arm", locked, 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule